// File: doc/BRIEF.md
# Masked Interrupt Router

This block gathers 32 level-sensitive interrupt lines from peripherals and steers each of them onto one of a small set of output lines that feed a parent CPU interrupt controller. Software controls it through a 32-bit register port: a mask word enables inputs individually, a status word shows which enabled inputs are currently asserted, and four routing words hold one 4-bit route field per input.

A route field of zero leaves its input unconnected. A non-zero value v selects output v-1. The number of outputs is a parameter between 1 and 15, and route values that point past the last output behave like zero. Each output is the OR of every asserted, enabled input routed to it. The outputs are registered, so they are free of glitches and follow the inputs one clock later. Priority, vectoring and edge capture are left to the parent controller.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask word and all four routing words are zero, every word in the window reads 0, and irq_out is all zeros.
- R2: The mask word sits at byte offset 0x00 and can be read and written. Bit i set to 1 enables input i. An input whose mask bit is 0 never drives any output.
- R3: The status word at offset 0x04 reads as irq_in AND mask. It is read-only: a write to 0x04 changes neither the mask nor the routing.
- R4: Routing words sit at offsets 0x08, 0x0C, 0x10 and 0x14. Input i uses the word at 0x08 + 4*(3 - i/8), in bits [s+3:s] with s = (4*i) mod 32. So inputs 24..31 are in 0x08 (input 24 in bits 3:0, input 31 in bits 31:28), and inputs 0..7 are in 0x14. All four words read back what was written.
- R5: A route field of 0 leaves its input disconnected, whatever the input and mask are.
- R6: A route field of v, with 1 <= v <= N_OUT, connects the input to irq_out[v-1]. Each output bit is the OR of all asserted, enabled inputs routed to it.
- R7: Route values greater than N_OUT (7..15 with the default N_OUT = 6) drive no output.
- R8: irq_out is registered. It reflects irq_in, mask and routing as sampled at the previous clock edge, and it falls one cycle after the inputs routed to it fall.
- R9: Reads have one cycle of latency: rdata is loaded at the clock edge that samples rd_en and then holds until the next read. Offsets 0x18 and 0x1C read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset in the register window (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_in | input | 32 | Level interrupt inputs from peripherals |
| irq_out | output | N_OUT | Level interrupt outputs to the parent controller |

## Verification
The routing table is driven with a single input on the lowest and the highest output, and with inputs at both ends of the index range (0, 8, 15, 18, 24, 31), so that an error in the nibble-reversed word selection or in the shift lands on the wrong output bit. Some patterns combine a masked and an unmasked input on neighbouring fields, which separates a mask fault from a routing fault. Others set route values of 0, of N_OUT+1 and of 15, which checks the disconnect rule and the out-of-range rule. One pattern routes every input to one output and enables only one of them, which exercises the OR merge under a mask. Directed tests cover the status word under writes, the unmapped offsets and a falling input.

// File: rtl/irq_router_pkg.sv
// Package: constants shared by the interrupt router and its checker.
// Assumes a fixed 32-input, 4-bit-field layout; output count is a top parameter.
package irq_router_pkg;
    localparam int IRQ_N     = 32;
    localparam int FIELD_W   = 4;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
    localparam int ROUTE_WORDS     = IRQ_N / FIELDS_PER_WORD;

    // Word index (addr[4:2]) of each register.
    localparam logic [2:0] W_MASK = 3'd0;
    localparam logic [2:0] W_STAT = 3'd1;
    localparam logic [2:0] W_RT0  = 3'd2;
    localparam logic [2:0] W_RT1  = 3'd3;
    localparam logic [2:0] W_RT2  = 3'd4;
    localparam logic [2:0] W_RT3  = 3'd5;
endpackage

// File: rtl/irq_regs.sv
// Register file: mask word, four routing words and the registered read mux.
// Assumes word addressing through addr[4:2]; unmapped words read 0 and ignore writes.
module irq_regs
    import irq_router_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    input  logic [IRQ_N-1:0]                 irq_in,
    output logic [WORD_W-1:0]                rdata,
    output logic [IRQ_N-1:0]                 mask_q,
    output logic [ROUTE_WORDS*WORD_W-1:0]    route_flat
);
    logic [2:0]                    word;
    logic [ROUTE_WORDS-1:0][WORD_W-1:0] route_q;
    logic [WORD_W-1:0]             rd_mux;

    assign word       = addr[ADDR_W-1:2];
    assign route_flat = route_q;

    // Mask word update; reset masks every input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en && word == W_MASK)
            mask_q <= wdata;
    end

    // Routing words update; reset disconnects every input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= '0;
        else if (wr_en) begin
            case (word)
                W_RT0:   route_q[0] <= wdata;
                W_RT1:   route_q[1] <= wdata;
                W_RT2:   route_q[2] <= wdata;
                W_RT3:   route_q[3] <= wdata;
                default: ;
            endcase
        end
    end

    // Read selection; status is the masked live input.
    always_comb begin
        case (word)
            W_MASK:  rd_mux = mask_q;
            W_STAT:  rd_mux = irq_in & mask_q;
            W_RT0:   rd_mux = route_q[0];
            W_RT1:   rd_mux = route_q[1];
            W_RT2:   rd_mux = route_q[2];
            W_RT3:   rd_mux = route_q[3];
            default: rd_mux = '0;
        endcase
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_route_decode.sv
// Route decoder: turns each input's 4-bit field into a per-output select column.
// Assumes the reversed word order (inputs 24..31 in word 0); values above N_OUT select nothing.
module irq_route_decode
    import irq_router_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic [ROUTE_WORDS*WORD_W-1:0] route_flat,
    output logic [N_OUT*IRQ_N-1:0]        sel_flat
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_in
        localparam int WIDX = (ROUTE_WORDS - 1) - (i / FIELDS_PER_WORD);
        localparam int LSB  = WIDX * WORD_W + (FIELD_W * i) % WORD_W;
        logic [FIELD_W-1:0] fld;
        assign fld = route_flat[LSB +: FIELD_W];
        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            // Field value k+1 selects output k.
            assign sel_flat[k*IRQ_N + i] = (fld == FIELD_W'(k + 1));
        end
    end
endmodule

// File: rtl/irq_out_merge.sv
// Output merge: ORs enabled, asserted inputs per output and registers the result.
// Assumes level inputs; no edge capture or priority.
module irq_out_merge
    import irq_router_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IRQ_N-1:0]       active,
    input  logic [N_OUT*IRQ_N-1:0] sel_flat,
    output logic [N_OUT-1:0]       irq_out
);
    logic [N_OUT-1:0] out_d;

    for (genvar k = 0; k < N_OUT; k++) begin : g_or
        assign out_d[k] = |(active & sel_flat[k*IRQ_N +: IRQ_N]);
    end

    // Output register; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= '0;
        else
            irq_out <= out_d;
    end
endmodule

// File: rtl/irq_router.sv
// Top: masked 32-input interrupt router with a 0x18-byte register window.
// Assumes synchronous active-low reset and 1 <= N_OUT <= 15.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic [IRQ_N-1:0]     irq_in,
    output logic [N_OUT-1:0]     irq_out
);
    logic [IRQ_N-1:0]              mask_q;
    logic [ROUTE_WORDS*WORD_W-1:0] route_flat;
    logic [N_OUT*IRQ_N-1:0]        sel_flat;

    irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .irq_in     (irq_in),
        .rdata      (rdata),
        .mask_q     (mask_q),
        .route_flat (route_flat)
    );

    irq_route_decode #(.N_OUT(N_OUT)) u_dec (
        .route_flat (route_flat),
        .sel_flat   (sel_flat)
    );

    irq_out_merge #(.N_OUT(N_OUT)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (irq_in & mask_q),
        .sel_flat (sel_flat),
        .irq_out  (irq_out)
    );
endmodule

// File: rtl/irq_router_chk.sv
// Checker: temporal properties of the router, bound onto the top module.
// Assumes it observes the top's ports and its mask word.
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [WORD_W-1:0]    rdata,
    input logic [IRQ_N-1:0]     irq_in,
    input logic [IRQ_N-1:0]     mask_q,
    input logic [N_OUT-1:0]     irq_out
);
    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0 && rdata == '0));

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_in & mask_q) == '0) |-> (irq_out == '0));

    // R3
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr[ADDR_W-1:2] == W_STAT) |-> (rdata == $past(irq_in & mask_q)));

    // R3
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr[ADDR_W-1:2] == W_STAT) |-> $stable(mask_q));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr[ADDR_W-1:2] > W_RT3) |-> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rdata));
endmodule

bind irq_router irq_router_chk #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .irq_out (irq_out)
);

// File: tb/sim_irq_router.sv
// Bench: vector table for routing, then directed reset and corner tests.
module sim_irq_router;
    localparam int NO = 6;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_in = '0;
    logic [NO-1:0] irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_router #(.N_OUT(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // mask, rt0(0x08), rt1(0x0C), rt2(0x10), rt3(0x14), irq_in, expected irq_out
    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] rt0;
        logic [31:0] rt1;
        logic [31:0] rt2;
        logic [31:0] rt3;
        logic [31:0] din;
        logic [NO-1:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        // R6 input 0 -> value 1 -> out0
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_0021, 32'h0000_0001, 6'b000001},
        // R6 input 1 -> value 2 -> out1
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_0021, 32'h0000_0002, 6'b000010},
        // R2 input 0 masked, input 1 enabled
        '{32'h0000_0002, 32'h0, 32'h0, 32'h0, 32'h0000_0021, 32'h0000_0003, 6'b000010},
        // R4 input 31 in top nibble of 0x08, value 6 -> out5
        '{32'hFFFF_FFFF, 32'h6000_0000, 32'h0, 32'h0, 32'h0000_0021, 32'h8000_0000, 6'b100000},
        // R7 input 31 value 7 ignored; R4 input 24 value 3 -> out2
        '{32'hFFFF_FFFF, 32'h7000_0003, 32'h0, 32'h0, 32'h0, 32'h8100_0000, 6'b000100},
        // R4 input 18 -> out4, input 8 -> out3; R7 input 15 value 15 ignored
        '{32'hFFFF_FFFF, 32'h0, 32'h0000_0500, 32'hF000_0004, 32'h0, 32'h0004_8100, 6'b011000},
        // R5 all fields zero
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 6'b000000},
        // R6 all to out0, only input 16 enabled
        '{32'h0001_0000, 32'h1111_1111, 32'h1111_1111, 32'h1111_1111, 32'h1111_1111, 32'h0001_0000, 6'b000001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 32'h0);
        for (int w = 0; w < 6; w++) begin
            rd(5'(w * 4), r);
            check("R1 reg", r, 32'h0);
        end

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr(5'h00, VEC[v].mask);
            wr(5'h08, VEC[v].rt0);
            wr(5'h0C, VEC[v].rt1);
            wr(5'h10, VEC[v].rt2);
            wr(5'h14, VEC[v].rt3);
            @(negedge clk);
            irq_in = VEC[v].din;
            @(negedge clk);
            check("R6 vector out", 32'(irq_out), 32'(VEC[v].exp));
            rd(5'h04, r);
            check("R3 status", r, VEC[v].din & VEC[v].mask);
        end

        // R4 routing readback
        wr(5'h10, 32'hA5C3_1E0F);
        rd(5'h10, r);
        check("R4 readback", r, 32'hA5C3_1E0F);
        rd(5'h00, r);
        check("R2 mask readback", r, 32'h0001_0000);

        // R3 write to status ignored
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h00, r);
        check("R3 status write mask", r, 32'h0001_0000);
        rd(5'h08, r);
        check("R3 status write route", r, 32'h1111_1111);

        // R9 unmapped offsets
        wr(5'h18, 32'hDEAD_BEEF);
        rd(5'h18, r);
        check("R9 unmapped 0x18", r, 32'h0);
        rd(5'h1C, r);
        check("R9 unmapped 0x1C", r, 32'h0);
        rd(5'h08, r);
        check("R9 write 0x18 no effect", r, 32'h1111_1111);

        // R8 level fall: input 16 still asserted and routed to out0
        @(negedge clk);
        check("R8 level high", 32'(irq_out), 32'h1);
        irq_in = 32'h0;
        @(negedge clk);
        check("R8 level fall", 32'(irq_out), 32'h0);

        // R8 registered: rise not seen before the edge
        @(negedge clk);
        irq_in = 32'h0001_0000;
        #2;
        check("R8 one cycle latency", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R8 rise", 32'(irq_out), 32'h1);

        // R1 reset clears live state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset out", 32'(irq_out), 32'h0);
        rd(5'h00, r);
        check("R1 reset mask", r, 32'h0);
        rd(5'h08, r);
        check("R1 reset route", r, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule